// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the timing strobes for a serial transmitter and receiver from a single system clock. It does not use an integer clock divisor. A phase accumulator adds a programmable mantissa on every clock. The accumulator's modulus is a power of two chosen by a programmable exponent. Each time the accumulator wraps, the block emits one oversample tick, so the oversample rate is f_clk × M / 2^(11+N). The bit rate is one sixteenth of that, f_clk × M / 2^(15+N), which reaches many standard rates from one clock.

Software writes a 32-bit rate word through a write strobe. The low twelve bits carry the mantissa M. The next four bits carry the exponent N. The block keeps the word in its own register. Every write restarts the phase from zero, so the first tick after a new setting arrives at a predictable time. A divide-by-sixteen stage turns the oversample strobe into a bit strobe that lines up with every sixteenth oversample tick.

Top module: `frac_baud_gen`

## Requirements
- R1: After synchronous reset both tick outputs are low and the stored rate word is zero, so no tick appears until the first write.
- R2: The mantissa is taken from bits [11:0] of the written word and the exponent from bits [15:12]. Bits [31:16] have no effect on the tick outputs.
- R3: For a mantissa M below 2^(11+N), the number of clocks with os_tick high in the T clocks after a write equals floor(T × M / 2^(11+N)).
- R4: bit_tick is high in exactly those clocks that carry the 16th, 32nd, 48th, and so on, os_tick after a write. bit_tick is therefore never high without os_tick.
- R5: A write clears the phase accumulator and the divide-by-16 count. Both ticks are low in the clock after the write edge, and counting restarts from zero even when the new word equals the old one.
- R6: A mantissa of zero produces no os_tick and no bit_tick, whatever the exponent.
- R7: The first os_tick after a write appears on the ceil(2^(11+N) / M)-th clock edge after the write edge.
- R8: The accumulator value always stays below the modulus 2^(11+N) of the current exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_wr | input | 1 | Write strobe for the rate word |
| baud_wdata | input | 32 | Rate word: mantissa in [11:0], exponent in [15:12] |
| os_tick | output | 1 | One-clock oversample strobe, 16 per bit |
| bit_tick | output | 1 | One-clock bit strobe, on every 16th oversample strobe |

## Verification
The embedded assertions check four properties on every clock:
- a zero mantissa keeps the oversample output silent;
- a write leaves both strobes low on the following clock;
- a bit strobe never appears without an oversample strobe;
- the accumulator stays inside the modulus of the current exponent.

The tick rates themselves can only be shown by the bench's scenarios. The bench counts strobes over long windows and compares the counts with the rate formula. It also measures when the first tick appears after a write and when the first bit strobe appears after a mid-run rewrite. These checks also cover the ignored upper bits of the rate word and the restart of the divide-by-16 phase.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int CFG_W      = 32;
    localparam int MANT_W     = 12;
    localparam int EXP_W      = 4;
    localparam int BASE_SHIFT = 11;
    localparam int OS_RATIO   = 16;
    localparam int ACC_W      = BASE_SHIFT + (1 << EXP_W) - 1;
    localparam int SUM_W      = ACC_W + 1;
    localparam int DIV_W      = $clog2(OS_RATIO);

    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } rate_t;

    function automatic rate_t decode_rate(input logic [CFG_W-1:0] word);
        rate_t r;
        r.mant = word[MANT_W-1:0];
        r.expo = word[MANT_W+EXP_W-1:MANT_W];
        return r;
    endfunction

    function automatic logic [SUM_W-1:0] rate_modulus(input logic [EXP_W-1:0] e);
        logic [SUM_W-1:0] one;
        one = SUM_W'(1);
        return one << (BASE_SHIFT + int'(e));
    endfunction
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output rate_t            rate_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else if (wr) begin
            rate_q <= decode_rate(wdata);
        end
    end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  rate_t            rate,
    output logic             carry,
    output logic             os_tick_q
);
    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] modulus;
    logic [SUM_W-1:0] wrap_mask;

    always_comb begin
        modulus   = rate_modulus(rate.expo);
        wrap_mask = modulus - SUM_W'(1);
        sum       = {1'b0, acc_q} + SUM_W'(rate.mant);
        carry     = (sum >= modulus);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q     <= '0;
            os_tick_q <= 1'b0;
        end else begin
            acc_q     <= ACC_W'(sum & wrap_mask);
            os_tick_q <= carry;
        end
    end

    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, acc_q} < rate_modulus(rate.expo))) else $error("acc out of range"); // R8

    AST_ZERO_MANT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (rate.mant == '0 && !clr) |=> !os_tick_q) else $error("tick with zero mantissa"); // R6
endmodule

// File: rtl/fbg_tick_div.sv
module fbg_tick_div
    import fbg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic carry,
    input  logic os_tick,
    output logic bit_tick_q
);
    logic [DIV_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == DIV_W'(OS_RATIO - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q      <= '0;
            bit_tick_q <= 1'b0;
        end else begin
            bit_tick_q <= carry && last;
            if (carry) begin
                cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
            end
        end
    end

    AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (rst)
        bit_tick_q |-> os_tick) else $error("bit tick without os tick"); // R4
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_wr,
    input  logic [CFG_W-1:0] baud_wdata,
    output logic             os_tick,
    output logic             bit_tick
);
    rate_t rate;
    logic  carry;

    fbg_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (baud_wr),
        .wdata  (baud_wdata),
        .rate_q (rate)
    );

    fbg_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (baud_wr),
        .rate      (rate),
        .carry     (carry),
        .os_tick_q (os_tick)
    );

    fbg_tick_div u_div (
        .clk        (clk),
        .rst        (rst),
        .clr        (baud_wr),
        .carry      (carry),
        .os_tick    (os_tick),
        .bit_tick_q (bit_tick)
    );

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        baud_wr |=> (!os_tick && !bit_tick)) else $error("tick after write"); // R5
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        baud_wr = 1'b0;
    logic [31:0] baud_wdata = '0;
    logic        os_tick;
    logic        bit_tick;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int NVEC = 6;
    localparam logic [31:0] VEC_CFG [NVEC] = '{
        32'h0000_0400, 32'h0000_07FF, 32'h0000_4003,
        32'h0000_23E8, 32'hABCD_0400, 32'h0000_F7FF
    };
    localparam int VEC_LEN [NVEC] = '{1000, 2000, 20000, 5000, 1000, 70000};

    always #2 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk        (clk),
        .rst        (rst),
        .baud_wr    (baud_wr),
        .baud_wdata (baud_wdata),
        .os_tick    (os_tick),
        .bit_tick   (bit_tick)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write at a falling edge, return at the falling edge just after the write edge.
    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        baud_wr    = 1'b1;
        baud_wdata = w;
        @(negedge clk);
        baud_wr    = 1'b0;
        baud_wdata = '0;
    endtask

    task automatic count_ticks(input int t, output longint n_os, output longint n_bit);
        n_os  = 0;
        n_bit = 0;
        for (int i = 0; i < t; i++) begin
            @(negedge clk);
            if (os_tick)  n_os++;
            if (bit_tick) n_bit++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        longint os_c, bit_c, expect_os;
        int first;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 os_tick in reset", os_tick, 0);
        chk("R1 bit_tick in reset", bit_tick, 0);
        rst = 1'b0;
        count_ticks(200, os_c, bit_c);
        chk("R1 no ticks before first write", os_c + bit_c, 0);

        // Vector table: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            longint m;
            int     e;
            m = longint'(VEC_CFG[v][11:0]);
            e = int'(VEC_CFG[v][15:12]);
            write_cfg(VEC_CFG[v]);
            chk("R5 ticks low after write", os_tick | bit_tick, 0);
            expect_os = (longint'(VEC_LEN[v]) * m) >>> (11 + e);
            count_ticks(VEC_LEN[v], os_c, bit_c);
            if (VEC_CFG[v][31:16] != 16'h0)
                chk("R2 upper bits ignored, os count", os_c, expect_os);
            else
                chk("R3 os tick count", os_c, expect_os);
            chk("R4 bit tick count", bit_c, expect_os / 16);
        end

        // R6: zero mantissa with a nonzero exponent
        write_cfg(32'h0000_3000);
        count_ticks(3000, os_c, bit_c);
        chk("R6 zero mantissa silent", os_c + bit_c, 0);

        // R7: first tick timing, M=1000 N=2 -> ceil(8192/1000) = 9
        write_cfg(32'h0000_23E8);
        first = 0;
        for (int i = 1; i <= 50; i++) begin
            @(negedge clk);
            if (os_tick && first == 0) first = i;
        end
        chk("R7 first os tick edge", first, 9);

        // R5: a rewrite of the same word restarts accumulator and divider
        write_cfg(32'h0000_0400);
        repeat (21) @(negedge clk);
        write_cfg(32'h0000_0400);
        os_c  = 0;
        first = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (os_tick && i <= 31) os_c++;
            if (bit_tick && first == 0) first = i;
        end
        chk("R5 os count after rewrite", os_c, 15);
        chk("R5 first bit tick after rewrite", first, 32);

        // R1: reset mid-run silences outputs
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 os_tick after mid-run reset", os_tick, 0);
        rst = 1'b0;
        count_ticks(100, os_c, bit_c);
        chk("R1 reset clears rate word", os_c, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule